// File: doc/BRIEF.md
# Shift-Add Serial Multiplier

This block multiplies two unsigned N-bit numbers. The multiplicand is captured in parallel when a start pulse arrives. The multiplier then enters one bit per clock, least significant bit first. On every step, the captured multiplicand is gated by the incoming bit. A single N-bit adder, together with its carry out, adds that gated value to a registered partial sum. The (N+1)-bit result is shifted right by one place. The bit that falls out is the next low-order product bit, so the low half of the product leaves serially. After N steps the high half sits in the partial-sum register, where it can be read in parallel and `done` is raised.

A caller pulses `start` with the multiplicand on `a_in`. It then presents the multiplier bits on `b_bit` for the next N clocks. It collects `prod_bit` on each cycle that `prod_valid` is high, and reads `hi_out` once `done` is set.

Top module: `serial_mult`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it goes high, `busy`, `done` and `prod_valid` are 0 and `hi_out` is all zeros.
- R2: A clock edge with `start` high captures `a_in` and clears the partial sum and the step count. After that edge, `busy` is 1, `done` is 0 and `hi_out` is 0.
- R3: On each of the N edges after a start edge, `b_bit` is consumed. After the k-th such edge (k = 0 for the first), `prod_valid` is 1 and `prod_bit` equals bit k of the product A*B.
- R4: After the N-th consuming edge, `busy` is 0 and `done` is 1. `hi_out` then equals bits 2N-1 down to N of A*B.
- R5: While idle (`busy` low and no start), `done` and `hi_out` hold their values and `prod_valid` is 0, whatever `a_in` and `b_bit` do.
- R6: `start` has priority. Raising it while busy abandons the current product and begins a new one with the `a_in` present at that edge. The `b_bit` at that edge is not consumed.
- R7: Changes on `a_in` after the start edge do not affect the product.
- R8: The product is correct for every pair of N-bit operands, including the all-ones pair, where the adder's carry out is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new multiplication, capturing `a_in` |
| a_in | input | N | Parallel multiplicand |
| b_bit | input | 1 | Serial multiplier bit, LSB first |
| busy | output | 1 | Steps remain in the current multiplication |
| prod_bit | output | 1 | Low-half product bit emitted this cycle |
| prod_valid | output | 1 | `prod_bit` is valid |
| done | output | 1 | High half ready on `hi_out` |
| hi_out | output | N | Upper N bits of the product |

## Verification
The all-ones operand pair exercises the adder's carry out. A design that drops the carry gets the top product bit wrong. A restart issued in the middle of a product checks that the partial sum and step count really clear. A stale sum would corrupt every later bit, and a counter that is not reset would end the new product early. The bench also changes `a_in` while the multiplier bits are being fed, and shows that a design which fails to latch the operand computes a mixed product. Finally, it toggles the inputs while the block is idle. A design that keeps accumulating there would disturb `hi_out` or raise `prod_valid` with nothing started.

// File: rtl/serial_mult.sv
module serial_mult #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] a_in,
  input  logic         b_bit,
  output logic         busy,
  output logic         prod_bit,
  output logic         prod_valid,
  output logic         done,
  output logic [N-1:0] hi_out
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [N-1:0]  a_q;
  logic [N-1:0]  psum;
  logic [CW-1:0] step;
  logic          active;
  logic [N:0]    sum;

  assign sum    = {1'b0, psum} + {1'b0, a_q & {N{b_bit}}};
  assign busy   = active;
  assign hi_out = psum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q        <= '0;
      psum       <= '0;
      step       <= '0;
      active     <= 1'b0;
      done       <= 1'b0;
      prod_bit   <= 1'b0;
      prod_valid <= 1'b0;
    end else if (start) begin
      a_q        <= a_in;
      psum       <= '0;
      step       <= '0;
      active     <= 1'b1;
      done       <= 1'b0;
      prod_valid <= 1'b0;
    end else if (active) begin
      psum       <= sum[N:1];
      prod_bit   <= sum[0];
      prod_valid <= 1'b1;
      step       <= step + 1'b1;
      if (step == LAST) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end else begin
      prod_valid <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !done && !prod_valid); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done && hi_out == '0); // R2
  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid |-> $past(busy) && !$past(start)); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(done) && $stable(hi_out) && !prod_valid); // R5
endmodule

// File: tb/sim_serial_mult.sv
module sim_serial_mult;
  localparam int N = 5;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, b_bit = 1'b0;
  logic [N-1:0] a_in = '0;
  logic busy, prod_bit, prod_valid, done;
  logic [N-1:0] hi_out;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_mult #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_bit(b_bit),
    .busy(busy), .prod_bit(prod_bit), .prod_valid(prod_valid),
    .done(done), .hi_out(hi_out)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_start(input logic [N-1:0] a);
    start = 1'b1; a_in = a; b_bit = 1'b0;
    tick();
    start = 1'b0;
    chk("R2 busy", busy, 1); chk("R2 done", done, 0); chk("R2 hi_out", hi_out, 0);
  endtask

  task automatic feed(input logic [N-1:0] a, input logic [N-1:0] b, input bit scramble_a);
    logic [2*N-1:0] p = a * b;
    for (int k = 0; k < N; k++) begin
      b_bit = b[k];
      if (scramble_a) a_in = ~a ^ N'(k);
      tick();
      chk("R3 valid", prod_valid, 1);
      chk(scramble_a ? "R7 bit" : "R3 bit", prod_bit, p[k]);
    end
    chk("R4 done", done, 1); chk("R4 busy", busy, 0);
    chk(scramble_a ? "R7 hi" : "R8 hi", hi_out, p[2*N-1:N]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 valid", prod_valid, 0); chk("R1 hi", hi_out, 0);
    rst_n = 1'b1; tick();
    chk("R1 busy post", busy, 0); chk("R1 hi post", hi_out, 0);
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++) begin
        do_start(N'(a));
        feed(N'(a), N'(b), 0);
      end
  endtask

  task automatic t_idle();
    logic [N-1:0] h;
    do_start('1); feed('1, '1, 0);
    h = hi_out;
    for (int k = 0; k < 4; k++) begin
      b_bit = 1'b1; a_in = N'(k * 7 + 3);
      tick();
      chk("R5 done", done, 1); chk("R5 hi", hi_out, h); chk("R5 valid", prod_valid, 0);
    end
  endtask

  task automatic t_restart();
    do_start(N'(7));
    b_bit = 1'b1; tick(); tick();
    start = 1'b1; a_in = N'(11); b_bit = 1'b1;
    tick();
    start = 1'b0;
    chk("R6 busy", busy, 1); chk("R6 hi", hi_out, 0); chk("R6 valid", prod_valid, 0);
    feed(N'(11), N'(13), 0);
  endtask

  task automatic t_a_change();
    do_start(N'(19)); feed(N'(19), N'(27), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_exhaustive();
    t_idle();
    t_restart();
    t_a_change();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule